// File: doc/BRIEF.md
# CAN Transmit Bit Monitor with Stuffing and Error Classification

This block sits on the transmit side of a CAN protocol controller and advances one step on each bit-time strobe. An upstream frame sequencer presents unstuffed frame bits one at a time. Each bit carries a start-of-frame marker, an arbitration-field marker and an end-of-frame marker. The block takes a bit from the sequencer with a one-cycle take pulse. After five equal bits in a row it inserts a stuff bit of the opposite value and takes nothing on that strobe. It drives the result on the transmit line. Logic 0 is the dominant bus level and logic 1 is the recessive level.

On each strobe the block compares the bit it drove during the previous bit time with the sampled receive bit. A mismatch is either lost arbitration or an error. The block writes a 3-bit last-error code, drives a six-bit dominant error flag and updates an 8-bit transmit error counter.

A recessive stuff bit that is overwritten with dominant is always treated as a stuff error, even inside the arbitration field. In that field the error is not charged to the counter. Any other recessive identifier bit that is overwritten there means arbitration was lost, and the block falls silent until the next start-of-frame.

Top module: `can_tx_bitmon`

## Requirements
- R1: After five consecutive driven bits of one value, the start-of-frame bit included, the next driven bit is a stuff bit of the opposite value, and `frm_take` stays low on that strobe. For identifier 0x010 this gives recessive stuff bits at bit times 5 and 14 of the frame.
- R2: Driving dominant (0) and sampling recessive (1) is a bit-0 error in any field: `lec` becomes 5 and `tec` rises by 8.
- R3: Driving a recessive data bit outside the arbitration field and sampling dominant is a bit-1 error: `lec` becomes 4 and `tec` rises by 8.
- R4: Driving a recessive non-stuff bit inside the arbitration field and sampling dominant pulses `arb_lost` high for one clock. `lec` and `tec` are left unchanged and no error flag is driven. `tx_bit` stays recessive until the next start-of-frame bit.
- R5: Driving a recessive stuff bit and sampling dominant is a stuff error: `lec` becomes 1. `tec` is unchanged when the stuff bit lies in the arbitration field and rises by 8 otherwise.
- R6: After any error, `tx_bit` is dominant and `eflag_active` is high for exactly the six bit times that follow the detecting strobe. During that time no comparison is made and no bit is taken; the line is recessive afterwards.
- R7: `tec` increments saturate at 255. Each frame whose final bit is checked without error lowers `tec` by 1, stopping at 0.
- R8: `lec` is 0 after reset and holds its value until the next error or a `lec_rd` pulse, which sets it to 7. An error detected in the same cycle as a read wins.
- R9: While idle or after lost arbitration, bits without the start-of-frame marker are taken and discarded, and `tx_bit` stays recessive.
- R10: During and after reset, `tx_bit` is 1, `arb_lost` is 0, `lec` is 0, `eflag_active` is 0 and `tec` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle pulse at each bit-time boundary |
| frm_valid | input | 1 | Sequencer is presenting a bit |
| frm_bit | input | 1 | Presented frame bit (0 dominant) |
| frm_sof | input | 1 | Presented bit is start-of-frame |
| frm_arb | input | 1 | Presented bit lies in the arbitration field |
| frm_last | input | 1 | Presented bit is the last bit of the frame |
| frm_take | output | 1 | Presented bit is consumed on this strobe |
| rx_bit | input | 1 | Bus level sampled for the bit time now ending |
| lec_rd | input | 1 | Read strobe for the last-error code |
| tx_bit | output | 1 | Transmit line level |
| arb_lost | output | 1 | One-clock pulse on lost arbitration |
| lec | output | 3 | Last-error code |
| eflag_active | output | 1 | Active error flag is being driven |
| tec | output | 8 | Transmit error counter |

## Verification
The hardest case to reach from the ports is a dominant level overwriting a recessive stuff bit inside the arbitration field. It only occurs when the frame content forces a stuff bit there, and when the bus is corrupted in exactly that bit time. The bench sends identifier 0x010, which places stuff bits at bit times 5 and 14. It counts bit times from the strobe that takes the start-of-frame bit and forces the sampled level dominant only during bit time 5. To tell this case apart from lost arbitration and from a bit-1 error, the same frame is corrupted at bit time 8 (a plain recessive identifier bit) and at bit time 15 (a recessive data bit). The counter is first driven away from zero, so that the unchanged counter in the stuff-error case can be seen.

// File: rtl/can_txm_pkg.sv
package can_txm_pkg;

   typedef enum logic [1:0] {
      M_IDLE = 2'd0,
      M_TX   = 2'd1,
      M_FLAG = 2'd2,
      M_LOST = 2'd3
   } txm_mode_e;

   localparam int LEC_W = 3;

   localparam logic [LEC_W-1:0] LEC_NONE  = 3'd0;
   localparam logic [LEC_W-1:0] LEC_STUFF = 3'd1;
   localparam logic [LEC_W-1:0] LEC_BIT1  = 3'd4;
   localparam logic [LEC_W-1:0] LEC_BIT0  = 3'd5;
   localparam logic [LEC_W-1:0] LEC_READ  = 3'd7;

endpackage

// File: rtl/can_txm_stuff.sv
module can_txm_stuff #(
   parameter int RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic restart,
   input  logic load_bit,
   output logic need_stuff,
   output logic run_val
);

   localparam int CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

   logic [CW-1:0] cnt_q;
   logic          val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         val_q <= 1'b1;
      end else if (load) begin
         if (restart || (load_bit != val_q)) begin
            cnt_q <= CW'(1);
            val_q <= load_bit;
         end else if (cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign need_stuff = (cnt_q == FULL);
   assign run_val    = val_q;

endmodule

// File: rtl/can_txm_class.sv
module can_txm_class
   import can_txm_pkg::*;
#(
   parameter bit ARB_STUFF_FREE = 1'b1
) (
   input  logic             chk_en,
   input  logic             drv_bit,
   input  logic             smp_bit,
   input  logic             is_stuff,
   input  logic             in_arb,
   output logic             err,
   output logic [LEC_W-1:0] code,
   output logic             charge,
   output logic             lost
);

   logic mism;
   logic stuff_charge;

   assign mism = chk_en && (drv_bit != smp_bit);

   generate
      if (ARB_STUFF_FREE) begin : g_exempt
         assign stuff_charge = !in_arb;
      end else begin : g_always
         assign stuff_charge = 1'b1;
      end
   endgenerate

   always_comb begin
      err    = 1'b0;
      code   = LEC_NONE;
      charge = 1'b0;
      lost   = 1'b0;
      if (mism) begin
         if (!drv_bit) begin
            err    = 1'b1;
            code   = LEC_BIT0;
            charge = 1'b1;
         end else if (is_stuff) begin
            err    = 1'b1;
            code   = LEC_STUFF;
            charge = stuff_charge;
         end else if (in_arb) begin
            lost   = 1'b1;
         end else begin
            err    = 1'b1;
            code   = LEC_BIT1;
            charge = 1'b1;
         end
      end
   end

endmodule

// File: rtl/can_txm_tec.sv
module can_txm_tec #(
   parameter int W   = 8,
   parameter int INC = 8,
   parameter int DEC = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] tec
);

   localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};
   localparam logic [W:0] INCV = (W+1)'(INC);
   localparam logic [W:0] DECV = (W+1)'(DEC);

   logic [W-1:0] tec_q;
   logic [W:0]   up;

   assign up = {1'b0, tec_q} + INCV;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tec_q <= '0;
      end else if (inc) begin
         tec_q <= (up > MAXV) ? MAXV[W-1:0] : up[W-1:0];
      end else if (dec) begin
         tec_q <= ({1'b0, tec_q} > DECV) ? (tec_q - DECV[W-1:0]) : '0;
      end
   end

   assign tec = tec_q;

endmodule

// File: rtl/can_tx_bitmon.sv
module can_tx_bitmon
   import can_txm_pkg::*;
#(
   parameter int RUN_LEN        = 5,
   parameter int FLAG_LEN       = 6,
   parameter int TEC_W          = 8,
   parameter int TEC_INC        = 8,
   parameter int TEC_DEC        = 1,
   parameter bit ARB_STUFF_FREE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             frm_valid,
   input  logic             frm_bit,
   input  logic             frm_sof,
   input  logic             frm_arb,
   input  logic             frm_last,
   output logic             frm_take,
   input  logic             rx_bit,
   input  logic             lec_rd,
   output logic             tx_bit,
   output logic             arb_lost,
   output logic [LEC_W-1:0] lec,
   output logic             eflag_active,
   output logic [TEC_W-1:0] tec
);

   localparam int FW = (FLAG_LEN > 1) ? $clog2(FLAG_LEN) : 1;
   localparam logic [FW-1:0] FLAG_LOAD = FW'(FLAG_LEN - 1);

   initial begin : p_param_chk
      assert (RUN_LEN >= 2) else $error("RUN_LEN must be at least 2");
      assert (FLAG_LEN >= 1) else $error("FLAG_LEN must be at least 1");
      assert (TEC_INC < (1 << TEC_W)) else $error("TEC_INC exceeds counter range");
      assert (TEC_DEC >= 1) else $error("TEC_DEC must be at least 1");
   end

   txm_mode_e        mode_q, mode_n;
   logic             tx_q, tx_n;
   logic             stuff_q, stuff_n;
   logic             arb_q, arb_n;
   logic             last_q, last_n;
   logic [FW-1:0]    flag_q, flag_n;
   logic [LEC_W-1:0] lec_q;
   logic             lost_q;

   logic             take;
   logic             ld;
   logic             ld_bit;
   logic             rst_run;
   logic             frame_ok;
   logic             accept;
   logic             need_stuff;
   logic             run_val;
   logic             chk_en;
   logic             cls_err;
   logic [LEC_W-1:0] cls_code;
   logic             cls_charge;
   logic             cls_lost;

   assign chk_en = bit_stb && (mode_q == M_TX);

   can_txm_class #(
      .ARB_STUFF_FREE(ARB_STUFF_FREE)
   ) u_class (
      .chk_en  (chk_en),
      .drv_bit (tx_q),
      .smp_bit (rx_bit),
      .is_stuff(stuff_q),
      .in_arb  (arb_q),
      .err     (cls_err),
      .code    (cls_code),
      .charge  (cls_charge),
      .lost    (cls_lost)
   );

   can_txm_stuff #(
      .RUN_LEN(RUN_LEN)
   ) u_stuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld),
      .restart   (rst_run),
      .load_bit  (ld_bit),
      .need_stuff(need_stuff),
      .run_val   (run_val)
   );

   can_txm_tec #(
      .W  (TEC_W),
      .INC(TEC_INC),
      .DEC(TEC_DEC)
   ) u_tec (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cls_err && cls_charge),
      .dec  (frame_ok),
      .tec  (tec)
   );

   always_comb begin
      mode_n   = mode_q;
      tx_n     = tx_q;
      stuff_n  = stuff_q;
      arb_n    = arb_q;
      last_n   = last_q;
      flag_n   = flag_q;
      take     = 1'b0;
      ld       = 1'b0;
      ld_bit   = 1'b1;
      rst_run  = 1'b0;
      frame_ok = 1'b0;
      accept   = 1'b0;
      if (bit_stb) begin
         unique case (mode_q)
            M_TX: begin
               if (cls_err) begin
                  mode_n  = M_FLAG;
                  flag_n  = FLAG_LOAD;
                  tx_n    = 1'b0;
                  stuff_n = 1'b0;
               end else if (cls_lost) begin
                  mode_n  = M_LOST;
                  tx_n    = 1'b1;
                  stuff_n = 1'b0;
               end else if (last_q) begin
                  frame_ok = 1'b1;
                  mode_n   = M_IDLE;
                  tx_n     = 1'b1;
                  stuff_n  = 1'b0;
                  accept   = 1'b1;
               end else if (need_stuff) begin
                  tx_n    = ~run_val;
                  stuff_n = 1'b1;
                  last_n  = 1'b0;
                  ld      = 1'b1;
                  ld_bit  = ~run_val;
               end else if (frm_valid) begin
                  take    = 1'b1;
                  tx_n    = frm_bit;
                  stuff_n = 1'b0;
                  arb_n   = frm_arb;
                  last_n  = frm_last;
                  ld      = 1'b1;
                  ld_bit  = frm_bit;
               end else begin
                  mode_n  = M_IDLE;
                  tx_n    = 1'b1;
                  stuff_n = 1'b0;
               end
            end
            M_FLAG: begin
               if (flag_q == '0) begin
                  mode_n = M_IDLE;
                  tx_n   = 1'b1;
               end else begin
                  flag_n = flag_q - 1'b1;
               end
            end
            default: accept = 1'b1;
         endcase
         if (accept && frm_valid) begin
            take = 1'b1;
            if (frm_sof) begin
               mode_n  = M_TX;
               tx_n    = frm_bit;
               stuff_n = 1'b0;
               arb_n   = frm_arb;
               last_n  = frm_last;
               ld      = 1'b1;
               ld_bit  = frm_bit;
               rst_run = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= M_IDLE;
         tx_q    <= 1'b1;
         stuff_q <= 1'b0;
         arb_q   <= 1'b0;
         last_q  <= 1'b0;
         flag_q  <= '0;
      end else begin
         mode_q  <= mode_n;
         tx_q    <= tx_n;
         stuff_q <= stuff_n;
         arb_q   <= arb_n;
         last_q  <= last_n;
         flag_q  <= flag_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lec_q  <= LEC_NONE;
         lost_q <= 1'b0;
      end else begin
         lost_q <= cls_lost;
         if (cls_err) begin
            lec_q <= cls_code;
         end else if (lec_rd) begin
            lec_q <= LEC_READ;
         end
      end
   end

   assign frm_take     = take;
   assign tx_bit       = tx_q;
   assign arb_lost     = lost_q;
   assign lec          = lec_q;
   assign eflag_active = (mode_q == M_FLAG);

endmodule

// File: rtl/can_txm_chk.sv
module can_txm_chk #(
   parameter int TEC_W    = 8,
   parameter int FLAG_LEN = 6,
   parameter int TEC_INC  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_stb,
   input logic             tx_bit,
   input logic             arb_lost,
   input logic [2:0]       lec,
   input logic             eflag_active,
   input logic [TEC_W-1:0] tec
);

   localparam int CW = $clog2(FLAG_LEN + 2);
   localparam logic [TEC_W-1:0] TMAX = {TEC_W{1'b1}};
   localparam logic [TEC_W-1:0] TINC = TEC_W'(TEC_INC);

   logic [CW-1:0] fcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt <= '0;
      end else if (!eflag_active) begin
         fcnt <= '0;
      end else if (bit_stb) begin
         fcnt <= fcnt + 1'b1;
      end
   end

   // R6: the flag is dominant on the line
   a_r6_flag_dominant: assert property (@(posedge clk) disable iff (!rst_n)
      eflag_active |-> !tx_bit);

   // R6: the flag spans exactly FLAG_LEN bit times
   a_r6_flag_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eflag_active) |-> (fcnt == CW'(FLAG_LEN)));

   // R6: a flag starts only with an error code written
   a_r6_flag_has_code: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eflag_active) |-> (lec == 3'd1 || lec == 3'd4 || lec == 3'd5));

   // R4: lost arbitration is a single-clock pulse
   a_r4_lost_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |=> !arb_lost);

   // R4: lost arbitration charges nothing and raises no flag
   a_r4_lost_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> ($stable(tec) && !eflag_active));

   // R7: the counter moves only by the increment, the decrement or into saturation
   a_r7_tec_steps: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tec) |-> ((tec + 1'b1) == $past(tec) || tec == ($past(tec) + TINC)
                         || tec == TMAX));

   // R7: the counter moves only on a bit-time strobe
   a_r7_tec_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tec) |-> $past(bit_stb));

   // R8: only defined codes appear
   a_r8_lec_codes: assert property (@(posedge clk) disable iff (!rst_n)
      (lec == 3'd0 || lec == 3'd1 || lec == 3'd4 || lec == 3'd5 || lec == 3'd7));

   // R1: the line changes only at a bit boundary
   a_r1_tx_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_bit) |-> $past(bit_stb));

endmodule

bind can_tx_bitmon can_txm_chk #(
   .TEC_W   (TEC_W),
   .FLAG_LEN(FLAG_LEN),
   .TEC_INC (TEC_INC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_stb     (bit_stb),
   .tx_bit      (tx_bit),
   .arb_lost    (arb_lost),
   .lec         (lec),
   .eflag_active(eflag_active),
   .tec         (tec)
);

// File: tb/can_tx_bitmon_test.sv
module can_tx_bitmon_test;

   localparam int BIT_CLKS = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_stb = 1'b0;
   logic       frm_valid = 1'b0;
   logic       frm_bit = 1'b1;
   logic       frm_sof = 1'b0;
   logic       frm_arb = 1'b0;
   logic       frm_last = 1'b0;
   logic       frm_take;
   logic       rx_bit = 1'b1;
   logic       lec_rd = 1'b0;
   logic       tx_bit;
   logic       arb_lost;
   logic [2:0] lec;
   logic       eflag_active;
   logic [7:0] tec;

   can_tx_bitmon uut (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frm_valid(frm_valid),
      .frm_bit(frm_bit), .frm_sof(frm_sof), .frm_arb(frm_arb), .frm_last(frm_last),
      .frm_take(frm_take), .rx_bit(rx_bit), .lec_rd(lec_rd), .tx_bit(tx_bit),
      .arb_lost(arb_lost), .lec(lec), .eflag_active(eflag_active), .tec(tec)
   );

   always #10 clk = ~clk;

   typedef struct packed { logic b; logic sof; logic arb; logic last; } ent_t;
   ent_t dq[$];

   int checks = 0;
   int errors = 0;
   int div = 0;
   int idx = 1000;
   int inj_idx = -1;
   logic inj_val = 1'b0;
   logic take_pend = 1'b0;
   int lost_cnt = 0;
   int txlog[64];
   int eflog[64];

   // behavioural reference state
   int   m_state;   // 0 idle, 1 sending, 2 flag, 3 silent after lost arbitration
   int   m_left;
   int   m_lec, m_tec;
   logic m_tx, m_stuff, m_arb, m_last, m_lost, m_err, m_charge, m_take;
   int   m_code, was, acc;
   logic hist[$];

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit five_same();
      if (hist.size() < 5) return 1'b0;
      for (int k = 1; k < 5; k++)
         if (hist[hist.size()-1-k] != hist[hist.size()-1]) return 1'b0;
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_tx = 1; m_stuff = 0; m_arb = 0; m_last = 0; m_left = 0;
         m_lec = 0; m_tec = 0; m_lost = 0; m_err = 0;
         hist.delete();
      end else begin
         m_err = 0; m_charge = 0; m_take = 0; m_lost = 0; m_code = 0;
         if (bit_stb) begin
            was = m_state;
            acc = (was == 0 || was == 3) ? 1 : 0;
            if (was == 1) begin
               if (m_tx != rx_bit) begin
                  if (!m_tx) begin m_err = 1; m_code = 5; m_charge = 1; end
                  else if (m_stuff) begin m_err = 1; m_code = 1; m_charge = !m_arb; end
                  else if (m_arb) m_lost = 1;
                  else begin m_err = 1; m_code = 4; m_charge = 1; end
               end
               if (m_err) begin m_state = 2; m_left = 6; m_tx = 0; m_stuff = 0; end
               else if (m_lost) begin m_state = 3; m_tx = 1; m_stuff = 0; end
               else if (m_last) begin
                  m_state = 0; m_tx = 1; m_stuff = 0; acc = 1;
                  m_tec = (m_tec > 0) ? m_tec - 1 : 0;
               end else if (five_same()) begin
                  m_tx = !hist[hist.size()-1]; m_stuff = 1; m_last = 0;
                  hist.push_back(m_tx);
               end else if (frm_valid) begin
                  m_take = 1; m_tx = frm_bit; m_stuff = 0; m_arb = frm_arb;
                  m_last = frm_last; hist.push_back(frm_bit);
               end else begin
                  m_state = 0; m_tx = 1; m_stuff = 0;
               end
               if (m_err && m_charge) m_tec = (m_tec + 8 > 255) ? 255 : m_tec + 8;
               if (m_err) m_lec = m_code;
            end else if (was == 2) begin
               m_left--;
               if (m_left == 0) begin m_state = 0; m_tx = 1; end
            end
            if (acc != 0 && frm_valid) begin
               m_take = 1;
               if (frm_sof) begin
                  m_state = 1; m_tx = frm_bit; m_stuff = 0; m_arb = frm_arb;
                  m_last = frm_last;
                  hist.delete(); hist.push_back(frm_bit);
               end
            end
         end
         check("R1 frm_take", take_pend, m_take);
         if (lec_rd && !m_err) m_lec = 7;
         if (take_pend) begin
            if (frm_sof) idx = 0;
            void'(dq.pop_front());
         end
         if (bit_stb && !(take_pend && frm_sof)) idx++;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check("R1 tx_bit", tx_bit, m_tx);
         check("R4 arb_lost", arb_lost, m_lost);
         check("R8 lec", lec, m_lec);
         check("R6 eflag_active", eflag_active, (m_state == 2) ? 1 : 0);
         check("R7 tec", tec, m_tec);
         if (idx >= 0 && idx < 64) begin
            txlog[idx] = tx_bit;
            eflog[idx] = eflag_active;
         end
         if (arb_lost) lost_cnt++;
      end
      div = (div == BIT_CLKS - 1) ? 0 : div + 1;
      bit_stb = (div == BIT_CLKS - 1);
      frm_valid = (dq.size() != 0);
      if (dq.size() != 0) begin
         frm_bit = dq[0].b; frm_sof = dq[0].sof; frm_arb = dq[0].arb; frm_last = dq[0].last;
      end else begin
         frm_bit = 1; frm_sof = 0; frm_arb = 0; frm_last = 0;
      end
      rx_bit = (idx == inj_idx) ? inj_val : tx_bit;
      #5 take_pend = frm_take;
   end

   task automatic push(input logic b, input logic sof, input logic arb, input logic last);
      ent_t e;
      e.b = b; e.sof = sof; e.arb = arb; e.last = last;
      dq.push_back(e);
   endtask

   // identifier 0x010, remote bit 0, data 1 0 0 0 0 0 1
   task automatic send_frame(input int at, input logic val);
      logic [10:0] id;
      logic [6:0]  dat;
      id  = 11'h010;
      dat = 7'b1000001;
      @(negedge clk); #2;
      for (int k = 0; k < 64; k++) begin txlog[k] = 9; eflog[k] = 9; end
      inj_idx = at; inj_val = val;
      push(1'b0, 1'b1, 1'b1, 1'b0);
      for (int k = 10; k >= 0; k--) push(id[k], 1'b0, 1'b1, 1'b0);
      push(1'b0, 1'b0, 1'b1, 1'b0);
      for (int k = 6; k >= 0; k--) push(dat[k], 1'b0, 1'b0, (k == 0));
      repeat (40 * BIT_CLKS) @(negedge clk);
      inj_idx = -1;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int ones;
      repeat (5) @(negedge clk);
      check("R10 tx_bit", tx_bit, 1);
      check("R10 arb_lost", arb_lost, 0);
      check("R10 lec", lec, 0);
      check("R10 eflag_active", eflag_active, 0);
      check("R10 tec", tec, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      send_frame(-1, 1'b0);
      check("R1 stuff at 5", txlog[5], 1);
      check("R1 stuff at 14", txlog[14], 1);
      check("R1 stuff at 21", txlog[21], 1);
      check("R8 lec clean", lec, 0);
      check("R7 tec floor", tec, 0);

      send_frame(16, 1'b1);
      check("R2 lec", lec, 5);
      check("R2 tec", tec, 8);
      for (int k = 17; k <= 22; k++) begin
         check("R6 flag dominant", txlog[k], 0);
         check("R6 flag active", eflog[k], 1);
      end
      check("R6 flag end", txlog[23], 1);
      check("R6 flag end active", eflog[23], 0);

      send_frame(15, 1'b0);
      check("R3 lec", lec, 4);
      check("R3 tec", tec, 16);

      send_frame(5, 1'b0);
      check("R5 lec arb stuff", lec, 1);
      check("R5 tec arb stuff", tec, 16);
      check("R6 flag after stuff", txlog[6], 0);

      send_frame(21, 1'b0);
      check("R5 lec data stuff", lec, 1);
      check("R5 tec data stuff", tec, 24);

      lost_cnt = 0;
      send_frame(8, 1'b0);
      check("R4 pulse count", lost_cnt, 1);
      check("R4 lec kept", lec, 1);
      check("R4 tec kept", tec, 24);
      ones = 0;
      for (int k = 9; k <= 30; k++) if (txlog[k] == 1 && eflog[k] == 0) ones++;
      check("R4 silent", ones, 22);

      send_frame(-1, 1'b0);
      check("R7 decrement", tec, 23);

      @(negedge clk); #2 lec_rd = 1'b1;
      @(negedge clk); #2 lec_rd = 1'b0;
      @(negedge clk);
      check("R8 read code", lec, 7);

      send_frame(1, 1'b1);
      check("R2 lec arb field", lec, 5);
      check("R2 tec arb field", tec, 31);

      for (int n = 0; n < 29; n++) send_frame(0, 1'b1);
      check("R7 saturate", tec, 255);
      send_frame(-1, 1'b0);
      check("R7 after saturate", tec, 254);

      @(negedge clk); #2 lec_rd = 1'b1;
      send_frame(15, 1'b0);
      @(negedge clk); #2 lec_rd = 1'b0;
      check("R8 read during error", lec, 7);
      check("R7 saturate again", tec, 255);

      @(negedge clk); #2;
      for (int k = 0; k < 4; k++) push(1'b0, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 6; k++) begin
         repeat (BIT_CLKS) @(negedge clk);
         check("R9 idle recessive", tx_bit, 1);
      end
      check("R9 bits consumed", dq.size(), 0);
      check("R9 no flag", eflag_active, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule